// File: doc/BRIEF.md
# Registered-Bus Burst Initiator Sequencer

This block is the master-side control for a single burst on a registered parallel bus with a 64-bit multiplexed address/data path. A client gives it a start address, a command code, a requester identity, a tag, three bits of extra status and a byte count, and pulses `start`. The sequencer then drives one address phase and one attribute phase. It waits a bounded number of cycles for a target to claim the cycle and accepts target wait states only before the first data transfer. It then streams every data phase back to back, with no pause on the initiator side.

The frame signal is active low. It goes high so that it is already high during the final two data phases, which gives every agent its two-cycle response time. A target can ask to stop the burst in any data phase. The burst then ends on the data phase that closes a 128-byte address block, at least two phases later. The sequencer reports how many bytes moved, so the client can issue the rest as a new burst from that boundary. When no target claims the cycle by the subtractive decode point, the sequencer ends with a master-abort result.

Top module: `bseq_initiator`

## Requirements
- R1: After reset and whenever idle, `frame_n` is 1 and `busy`, `done` and `data_take` are 0.
- R2: The cycle after a `start` sampled while idle is the address phase: `frame_n`=0, `bus_ad`=start address, `bus_cbe`=command.
- R3: The cycle after that is the attribute phase: `bus_ad[63:32]`=0, `bus_ad[31:0]`={tag[3:0], byte count[11:0], requester id[15:0]}, `bus_cbe`={extra status[2:0], tag[4]}.
- R4: Claim cycles are numbered 1 to SLOW_POINT+2 (default 5), starting the cycle after the attribute phase. `devsel_n` low in any of them is a claim, and the next cycle is target wait cycle 0. No data moves during the claim cycles.
- R5: If there is no claim by the last claim cycle, the next cycle shows `done`=1, `done_abort`=1, `done_disc`=0 and `xfer_bytes`=0. No data phase happens.
- R6: In target wait cycles the sequencer keeps `frame_n` low and moves no data. For a read (cmd[0]=0), the first data phase is the cycle after the first wait cycle in which `trdy_n` is low.
- R7: For a write (cmd[0]=1), `trdy_n` low counts only in even-numbered wait cycles, so target wait states last a multiple of two cycles.
- R8: The burst has ceil(B/8) data phases, where B is the byte count and a count of 0 means 4096. The phases run on consecutive cycles with `data_take`=1 and `bus_ad`=`wr_data`. `trdy_n` is ignored once the phases have begun.
- R9: During data phases `frame_n` is 0, except in the final two data phases (the only one for a one-phase burst), where it is 1.
- R10: If `stop_n` is low in a data phase whose address holds the 8-byte slot s = address[6:3], the burst ends k phases later, where k = 15-s, or 31-s when that is below 2. It ends earlier if the planned burst runs out first.
- R11: The cycle after the last data phase shows a one-cycle `done` with `done_abort`=0. If the burst was cut short, `done_disc`=1 and `xfer_bytes`=8 times the phases moved. Otherwise `done_disc`=0 and `xfer_bytes`=B.
- R12: A `start` pulse while `busy` is 1 is ignored. The sequencer returns to idle after the current burst and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst (sampled while idle) |
| start_addr | input | 64 | Burst start address |
| cmd | input | 4 | Command code; bit 0 set means write |
| req_id | input | 16 | Requester identity for the attribute phase |
| byte_cnt | input | 12 | Burst byte count, 0 means 4096 |
| tag | input | 5 | Transaction tag |
| xstat | input | 3 | Extra attribute status bits |
| wr_data | input | 64 | Data placed on the bus in each data phase |
| devsel_n | input | 1 | Target claim, active low |
| trdy_n | input | 1 | Target ready before the first transfer, active low |
| stop_n | input | 1 | Target disconnect request, active low |
| frame_n | output | 1 | Frame, active low |
| bus_ad | output | 64 | Address / attribute / data lines |
| bus_cbe | output | 4 | Command / attribute / byte-enable lines |
| data_take | output | 1 | High in each data phase; the source advances |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_abort | output | 1 | Burst ended by master abort |
| done_disc | output | 1 | Burst ended early by target disconnect |
| xfer_bytes | output | 13 | Bytes moved by the finished burst |

## Verification
The address phase is due one cycle after `start` is sampled and the attribute phase one cycle after that. A claim in claim cycle n is followed by wait cycle 0 in the next cycle. The first data phase comes one cycle after the qualifying `trdy_n` sample, and `done` comes one cycle after the last data phase, or one cycle after the final claim cycle on an abort. The driver walks the burst one cycle at a time on falling edges and compares each output in the cycle these latencies predict. The scoreboard monitor compares each `done` result against a queue of results the driver computed in advance from the byte count, the stop position and the claim timing.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int BUS_W       = 64;
  localparam int PHASE_BYTES = BUS_W / 8;
  localparam int PB_LG       = $clog2(PHASE_BYTES);
  localparam int EDGE_BYTES  = 128;
  localparam int SLOTS       = EDGE_BYTES / PHASE_BYTES;
  localparam int SLOT_W      = $clog2(SLOTS);
  localparam int CNT_W       = 12;
  localparam int TOT_W       = CNT_W + 1;
  localparam int PH_W        = TOT_W - PB_LG + 1;
  localparam int ID_W        = 16;
  localparam int TAG_W       = 5;
  localparam int XST_W       = 3;
  localparam int CMD_W       = 4;
  localparam int ATTR_W      = ID_W + CNT_W + TAG_W + XST_W;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ATTR, S_CLAIM, S_TWAIT, S_DATA
  } seq_state_t;

  // Byte count field to real byte total (zero encodes the maximum).
  function automatic logic [TOT_W-1:0] burst_bytes(input logic [CNT_W-1:0] c);
    return (c == '0) ? TOT_W'(1 << CNT_W) : TOT_W'(c);
  endfunction

  // Data phases needed: bytes rounded up to whole bus words.
  function automatic logic [PH_W-1:0] burst_phases(input logic [TOT_W-1:0] b);
    logic [TOT_W:0] r;
    r = {1'b0, b} + (TOT_W+1)'(PHASE_BYTES - 1);
    return PH_W'(r >> PB_LG);
  endfunction

  // Phases after the current one until the block boundary closes,
  // pushed one block further when fewer than two remain.
  function automatic logic [SLOT_W:0] slots_to_edge(input logic [SLOT_W-1:0] s);
    logic [SLOT_W:0] k;
    k = (SLOT_W+1)'(SLOTS - 1) - {1'b0, s};
    if (k < 2) k = k + (SLOT_W+1)'(SLOTS);
    return k;
  endfunction

  function automatic logic [ATTR_W-1:0] pack_attr(input logic [ID_W-1:0] id,
                                                  input logic [TAG_W-1:0] tg,
                                                  input logic [CNT_W-1:0] cnt,
                                                  input logic [XST_W-1:0] xs);
    return {xs, tg, cnt, id};
  endfunction

  function automatic logic [TOT_W-1:0] moved_bytes(input logic [PH_W-1:0] ph,
                                                   input logic [TOT_W-1:0] tot,
                                                   input logic cut);
    return cut ? (TOT_W'(ph) << PB_LG) : tot;
  endfunction
endpackage

// File: rtl/bseq_claim_timer.sv
module bseq_claim_timer #(
  parameter int SUB_POINT = 5,
  localparam int CW = $clog2(SUB_POINT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic claim,
  output logic expire
);
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)                 count <= CW'(1);
    else if (count != CW'(SUB_POINT))   count <= count + CW'(1);
  end

  assign expire = run && !claim && (count == CW'(SUB_POINT));

  // R4
  claim_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (count >= CW'(1) && count <= CW'(SUB_POINT)));
endmodule

// File: rtl/bseq_burst_ctr.sv
module bseq_burst_ctr
  import bseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PH_W-1:0]   phases,
  input  logic [SLOT_W-1:0] slot0,
  input  logic              step,
  input  logic              stop_req,
  output logic [PH_W-1:0]   done_ph,
  output logic              last,
  output logic              tail
);
  logic [PH_W-1:0]   rem;
  logic [SLOT_W-1:0] slot;
  logic [PH_W-1:0]   rem_dec, cut;

  assign rem_dec = rem - PH_W'(1);
  assign cut     = PH_W'(slots_to_edge(slot));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem <= '0; slot <= '0; done_ph <= '0;
    end else if (load) begin
      rem <= phases; slot <= slot0; done_ph <= '0;
    end else if (step) begin
      rem     <= (stop_req && cut < rem_dec) ? cut : rem_dec;
      slot    <= slot + SLOT_W'(1);
      done_ph <= done_ph + PH_W'(1);
    end
  end

  assign last = (rem == PH_W'(1));
  assign tail = (rem <= PH_W'(2));

  // R8
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> phases != '0);
  // R8
  progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !last |=> rem < $past(rem));
  // R10
  cut_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && stop_req && !last |=> rem <= PH_W'(SLOTS + 1));
endmodule

// File: rtl/bseq_bus_drive.sv
module bseq_bus_drive
  import bseq_pkg::*;
(
  input  seq_state_t        st,
  input  logic [BUS_W-1:0]  addr,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ATTR_W-1:0] attr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              tail,
  output logic [BUS_W-1:0]  ad,
  output logic [CMD_W-1:0]  cbe,
  output logic              frame_n,
  output logic              data_take
);
  always_comb begin
    ad = '0; cbe = '0; frame_n = 1'b0; data_take = 1'b0;
    case (st)
      S_IDLE: frame_n = 1'b1;
      S_ADDR: begin ad = addr; cbe = cmd; end
      S_ATTR: begin
        ad  = {{(BUS_W-32){1'b0}}, attr[31:0]};
        cbe = attr[ATTR_W-1:32];
      end
      S_DATA: begin ad = wr_data; frame_n = tail; data_take = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/bseq_initiator.sv
module bseq_initiator
  import bseq_pkg::*;
#(
  parameter int SLOW_POINT = 3,
  localparam int SUB_POINT = SLOW_POINT + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BUS_W-1:0]  start_addr,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ID_W-1:0]   req_id,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [TAG_W-1:0]  tag,
  input  logic [XST_W-1:0]  xstat,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              devsel_n,
  input  logic              trdy_n,
  input  logic              stop_n,
  output logic              frame_n,
  output logic [BUS_W-1:0]  bus_ad,
  output logic [CMD_W-1:0]  bus_cbe,
  output logic              data_take,
  output logic              busy,
  output logic              done,
  output logic              done_abort,
  output logic              done_disc,
  output logic [TOT_W-1:0]  xfer_bytes
);
  seq_state_t        st;
  logic [BUS_W-1:0]  addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [ATTR_W-1:0] attr_q;
  logic [TOT_W-1:0]  tot_q;
  logic [PH_W-1:0]   plan_q;
  logic              wodd;

  // Named internal events
  logic ev_claim, ev_go, ev_end, ev_expire, ev_cut, last, tail;
  logic [PH_W-1:0] done_ph, moved_ph;

  assign ev_claim = (st == S_CLAIM) && !devsel_n;
  assign ev_go    = (st == S_TWAIT) && !trdy_n && (!cmd_q[0] || !wodd);
  assign ev_end   = (st == S_DATA) && last;
  assign moved_ph = done_ph + PH_W'(1);
  assign ev_cut   = moved_ph < plan_q;

  bseq_claim_timer #(.SUB_POINT(SUB_POINT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st == S_CLAIM), .claim(!devsel_n),
    .expire(ev_expire));

  bseq_burst_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ev_go), .phases(plan_q),
    .slot0(addr_q[SLOT_W+PB_LG-1:PB_LG]), .step(st == S_DATA),
    .stop_req(!stop_n), .done_ph(done_ph), .last(last), .tail(tail));

  bseq_bus_drive u_drive (
    .st(st), .addr(addr_q), .cmd(cmd_q), .attr(attr_q), .wr_data(wr_data),
    .tail(tail), .ad(bus_ad), .cbe(bus_cbe), .frame_n(frame_n),
    .data_take(data_take));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; addr_q <= '0; cmd_q <= '0; attr_q <= '0;
      tot_q <= '0; plan_q <= '0; wodd <= 1'b0;
      done <= 1'b0; done_abort <= 1'b0; done_disc <= 1'b0; xfer_bytes <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_ADDR;
          addr_q <= start_addr;
          cmd_q  <= cmd;
          attr_q <= pack_attr(req_id, tag, byte_cnt, xstat);
          tot_q  <= burst_bytes(byte_cnt);
          plan_q <= burst_phases(burst_bytes(byte_cnt));
        end
        S_ADDR: st <= S_ATTR;
        S_ATTR: st <= S_CLAIM;
        S_CLAIM:
          if (ev_claim) begin
            st <= S_TWAIT; wodd <= 1'b0;
          end else if (ev_expire) begin
            st <= S_IDLE; done <= 1'b1; done_abort <= 1'b1;
            done_disc <= 1'b0; xfer_bytes <= '0;
          end
        S_TWAIT:
          if (ev_go) st <= S_DATA;
          else       wodd <= !wodd;
        S_DATA:
          if (ev_end) begin
            st <= S_IDLE; done <= 1'b1; done_abort <= 1'b0;
            done_disc  <= ev_cut;
            xfer_bytes <= moved_bytes(moved_ph, tot_q, ev_cut);
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE);

  // R1
  idle_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> frame_n && !data_take);
  // R8
  no_initiator_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_take && !frame_n |=> data_take);
  // R9
  tail_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_take && frame_n && !ev_end |=> data_take && frame_n);
  // R5
  abort_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_abort |-> xfer_bytes == '0 && !done_disc);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TWAIT) && trdy_n |=> !data_take);
endmodule

// File: tb/bseq_initiator_test.sv
module bseq_initiator_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, devsel_n, trdy_n, stop_n;
  logic [63:0] start_addr, wr_data, bus_ad;
  logic [3:0]  cmd, bus_cbe;
  logic [15:0] req_id;
  logic [11:0] byte_cnt;
  logic [4:0]  tag;
  logic [2:0]  xstat;
  logic        frame_n, data_take, busy, done, done_abort, done_disc;
  logic [12:0] xfer_bytes;

  bseq_initiator uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .cmd(cmd), .req_id(req_id), .byte_cnt(byte_cnt), .tag(tag),
    .xstat(xstat), .wr_data(wr_data), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .frame_n(frame_n), .bus_ad(bus_ad), .bus_cbe(bus_cbe),
    .data_take(data_take), .busy(busy), .done(done), .done_abort(done_abort),
    .done_disc(done_disc), .xfer_bytes(xfer_bytes));

  int checks = 0, failures = 0;
  typedef struct { bit ab; bit dc; int by; } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      if (sb.size() == 0) chk(1'b0, "R11 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(done_abort == e.ab, "R5 abort flag", done_abort, e.ab);
        chk(done_disc == e.dc, "R11 disconnect flag", done_disc, e.dc);
        chk(int'(xfer_bytes) == e.by, "R11 byte total", xfer_bytes, e.by);
      end
    end
  end

  task automatic run(input logic [63:0] a, input logic [3:0] c, input logic [11:0] n,
                     input int claim_at, input int wt, input int stop_at, input bit poke);
    int tot, np, last_i, eff, w, s, k;
    bit wr;
    exp_t e;
    tot = (n == 0) ? 4096 : int'(n);
    np = (tot + 7) / 8;
    wr = c[0];
    last_i = np - 1;
    if (stop_at >= 0) begin
      s = (int'(a[6:3]) + stop_at) % 16;
      k = 15 - s;
      if (k < 2) k += 16;
      if (stop_at + k < last_i) last_i = stop_at + k;
    end
    e.ab = (claim_at == 0);
    e.dc = !e.ab && (last_i < np - 1);
    e.by = e.ab ? 0 : (e.dc ? (last_i + 1) * 8 : tot);
    sb.push_back(e);

    @(negedge clk);
    start = 1; start_addr = a; cmd = c; byte_cnt = n;
    req_id = a[15:0] ^ 16'h5A5A; tag = n[4:0] ^ 5'h15; xstat = c[2:0];
    @(negedge clk);
    start = 0;
    chk(!frame_n && bus_ad == a && bus_cbe == c, "R2 address phase", bus_ad, a);
    @(negedge clk);
    chk(!frame_n && bus_ad == {32'h0, tag[3:0], n, req_id}, "R3 attribute lines",
        bus_ad, {32'h0, tag[3:0], n, req_id});
    chk(bus_cbe == {xstat, tag[4]}, "R3 attribute cbe", bus_cbe, {xstat, tag[4]});
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      chk(!data_take && !frame_n && busy, "R4 claim cycle", data_take, 0);
      start = (poke && i == 2);
      devsel_n = (i == claim_at) ? 1'b0 : 1'b1;
      if (i == claim_at) break;
    end
    @(negedge clk);
    devsel_n = 1; start = 0;
    if (claim_at == 0) begin
      chk(!busy && !data_take && done, "R5 master abort", busy, 0);
      @(negedge clk);
      chk(!busy && frame_n, "R12 start while busy ignored", busy, 0);
      return;
    end
    eff = wr ? ((wt + 1) / 2) * 2 : wt;
    w = 0;
    while (!data_take) begin
      chk(!frame_n, "R6 frame held in wait", frame_n, 0);
      trdy_n = (w >= wt) ? 1'b0 : 1'b1;
      w++;
      @(negedge clk);
    end
    chk(w == eff + 1, wr ? "R7 write wait parity" : "R6 target wait", w, eff + 1);
    for (int idx = 0; idx <= last_i; idx++) begin
      trdy_n = 1;
      wr_data = {a[31:0] ^ 32'hC0DE_0000, 32'(idx)};
      stop_n = (idx == stop_at) ? 1'b0 : 1'b1;
      #1;
      chk(data_take && bus_ad == wr_data, "R8 data phase", bus_ad, wr_data);
      chk(frame_n == (idx >= last_i - 1), "R9 frame timing", frame_n, (idx >= last_i - 1));
      @(negedge clk);
    end
    stop_n = 1;
    chk(!data_take && !busy && done, "R10 R11 burst end", data_take, 0);
  endtask

  initial begin
    #(8 * 200000);
    failures++; checks++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; devsel_n = 1; trdy_n = 1; stop_n = 1;
    start_addr = '0; cmd = '0; req_id = '0; byte_cnt = '0; tag = '0;
    xstat = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(frame_n && !busy && !done && !data_take, "R1 reset state", frame_n, 1);
    rst_n = 1;
    @(negedge clk);
    chk(frame_n && !busy, "R1 idle after reset", busy, 0);
    run(64'h0000_0010_0000_1000, 4'h6, 12'd64,  1, 0, -1, 0); // R8 read, 8 phases
    run(64'h0000_0000_0000_2008, 4'h7, 12'd20,  3, 1, -1, 0); // R7 wait rounded to 2
    run(64'h0000_0000_0000_3000, 4'h7, 12'd8,   5, 0, -1, 0); // R4 subtractive, 1 phase
    run(64'h0000_0000_0000_4000, 4'h6, 12'd32,  0, 0, -1, 1); // R5 abort, R12 poke
    run(64'h0000_0000_0000_0040, 4'h6, 12'd0,   2, 3, -1, 0); // R8 zero means 4096
    run(64'h0000_0000_0000_0078, 4'h6, 12'd256, 1, 0,  0, 0); // R10 slot 15 -> 16 more
    run(64'h0000_0000_0000_0000, 4'h7, 12'd200, 2, 3,  4, 0); // R10 cut at 128 bytes
    run(64'h0000_0000_0000_0000, 4'h6, 12'd24,  1, 0,  0, 0); // R10 natural end first
    run(64'h0000_0000_0000_0070, 4'h6, 12'd12,  4, 2,  0, 0); // R10 short, no cut
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R11 all results seen", sb.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule